// File: doc/BRIEF.md
# Parallel-Bus SAR Conversion Sequencer

This block is the digital core of a 12-bit successive-approximation converter that talks to a host over a byte-wide parallel bus. The host writes an 8-bit control byte with the write strobe while chip select is low. The byte selects the input channel, the input pairing, the output coding, the acquisition mode and the power or clock mode. The block then runs an acquisition phase. The phase is either timed internally or held open until the host writes a second byte. After acquisition the block runs a 13-tick conversion that tests one trial code per tick against a 1-bit comparator input.

When the result is ready, the active-low interrupt falls. The host reads the result as a low byte and a high byte, chosen by the high-byte-enable input. The data bus is modelled as separate input, output and output-enable signals. The analog multiplexer, the DAC and the reference stay outside the block. The block drives them only through the channel select, the pairing flag and the trial-code outputs.

All logic runs on one system clock. The strobes and the external conversion clock are sampled and edge-detected. In internal clock mode the conversion ticks come from a fixed divider of the system clock.

Top module: `sar_seq`

## Requirements
- R1: After reset, int_no is 1, external clock mode is selected (int_clk_o=0), pwr_o is 2'b00 (running), hold_o is 0 and d_oe_o is 0.
- R2: A control byte on d_i is latched on a rising edge of wr_ni while cs_ni is low. The fields are, from bit 7 down to bit 0: power code (2 bits), acquisition mode (bit 5, 1 = host-timed), single-ended flag (bit 4), unipolar flag (bit 3) and channel (bits 2:0). chan_o and single_o show the latched fields.
- R3: With acquisition mode 0 and a running power code, acquisition lasts 4 conversion ticks and conversion lasts the next 13. int_no falls on the 17th tick after the write.
- R4: A write with acquisition mode 1 starts an acquisition that lasts until the next write, whatever the number of ticks. A following write with acquisition mode 0 starts conversion at once, and int_no falls on the 13th tick after it.
- R5: On the write that closes a host-timed acquisition, conv_bad_o becomes 1 if bits 4:0 differ from the opening byte. It becomes 0 if they match. A change in the power bits alone is allowed. Every other write clears conv_bad_o.
- R6: The conversion resolves trial bits MSB first, one per tick, keeping a bit when comp_i is 1. In unipolar mode (bit 3 = 1) the result is the straight binary code found.
- R7: In bipolar mode (bit 3 = 0) the result is the code found with its MSB inverted, that is two's complement. The high byte then carries copies of result bit 11 in bits 7:4.
- R8: While cs_ni and rd_ni are low, d_oe_o is 1. With hben_i=0, d_o carries result bits 7:0. With hben_i=1, d_o[3:0] carries result bits 11:8 and d_o[7:4] is zero in unipolar mode.
- R9: A write during a conversion aborts it. The interrupt of the aborted conversion never appears, and timing restarts from the new write.
- R10: int_no returns to 1 on a falling edge of rd_ni while cs_ni is low, and on any accepted write.
- R11: While cs_ni is 1, write and read strobes and external clock edges have no effect, and d_oe_o and int_oe_o are 0.
- R12: Power codes 2'b00 (pwr_o=2'b10) and 2'b01 (pwr_o=2'b01) start no conversion, so int_no stays 1, and keep the clock mode. Code 2'b10 selects the internal clock and code 2'b11 the external clock, both with pwr_o=2'b00.
- R13: In internal clock mode, one conversion tick occurs every INT_DIV system clocks without any activity on cclk_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| wr_ni | input | 1 | Write strobe, active low; latches on rising edge |
| rd_ni | input | 1 | Read strobe, active low |
| hben_i | input | 1 | High-byte select for the result |
| d_i | input | 8 | Data bus, inbound |
| d_o | output | 8 | Data bus, outbound |
| d_oe_o | output | 1 | Data bus output enable |
| int_no | output | 1 | Conversion-done interrupt, active low |
| int_oe_o | output | 1 | Interrupt output enable |
| cclk_i | input | 1 | External conversion clock; ticks on falling edge |
| comp_i | input | 1 | Comparator decision for the current trial code |
| trial_o | output | 12 | Trial code for the DAC |
| chan_o | output | 3 | Channel select for the analog multiplexer |
| single_o | output | 1 | 1 = single-ended, 0 = paired input |
| hold_o | output | 1 | 1 while converting (track/hold in hold) |
| pwr_o | output | 2 | 00 running, 01 standby, 10 full power-down |
| int_clk_o | output | 1 | 1 when the internal clock is selected |
| conv_bad_o | output | 1 | Closing byte differed from the opening byte |

## Verification
A wrong tick count or a wrong sequencer state shows first on int_no. That happens within one conversion: the interrupt falls one tick early, one tick late or not at all. The bench counts external clock pulses after each write and samples int_no at the 12th and 13th (or 16th and 17th) pulse. A wrong trial-bit order or a wrong coding shows on the two result bytes as soon as they are read. A failed abort or a lost power code shows as an interrupt that should not appear, or as a clock-mode flag that changed.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef struct packed {
    logic [1:0] pd;
    logic       acq_ext;
    logic       single;
    logic       uni;
    logic [2:0] chan;
  } ctl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PDN,
    ST_ACQ_INT,
    ST_ACQ_EXT,
    ST_CONV
  } seq_st_t;

  localparam ctl_t CTL_RESET = '{pd: 2'b11, acq_ext: 1'b0, single: 1'b0, uni: 1'b0, chan: 3'd0};
endpackage

// File: rtl/sar_cfg.sv
module sar_cfg
  import sar_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_evt_i,
  input  ctl_t new_i,
  output ctl_t cfg_o,
  output logic int_clk_o,
  output logic [1:0] pwr_o
);
  ctl_t cfg_q;
  logic ext_clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= CTL_RESET;
      ext_clk_q <= 1'b1;
    end else if (wr_evt_i) begin
      cfg_q <= new_i;
      if (new_i.pd[1]) ext_clk_q <= new_i.pd[0];
    end
  end

  assign cfg_o     = cfg_q;
  assign int_clk_o = ~ext_clk_q;
  assign pwr_o     = cfg_q.pd[1] ? 2'b00 : (cfg_q.pd[0] ? 2'b01 : 2'b10);

  AST_PD_KEEPS_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_evt_i && !new_i.pd[1]) |=> $stable(ext_clk_q)); // R12
endmodule

// File: rtl/sar_tick.sv
module sar_tick #(
  parameter int INT_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic cclk_i,
  input  logic int_clk_i,
  output logic tick_o
);
  localparam int DW = (INT_DIV > 2) ? $clog2(INT_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(INT_DIV - 1);

  logic cclk_q;
  logic [DW-1:0] div_q;
  logic ext_tick, div_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cclk_q <= 1'b0;
      div_q  <= '0;
    end else begin
      cclk_q <= cclk_i;
      div_q  <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
    end
  end

  assign ext_tick = cclk_q & ~cclk_i & ~cs_ni;
  assign div_tick = (div_q == DIV_LAST);
  assign tick_o   = int_clk_i ? div_tick : ext_tick;

  AST_CS_BLOCKS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && !int_clk_i) |-> !tick_o); // R11
endmodule

// File: rtl/sar_core.sv
module sar_core
  import sar_pkg::*;
#(
  parameter int RES_W     = 12,
  parameter int ACQ_TICKS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_evt_i,
  input  logic             rd_evt_i,
  input  logic             tick_i,
  input  ctl_t             new_i,
  input  ctl_t             cur_i,
  input  logic             comp_i,
  output logic [RES_W-1:0] trial_o,
  output logic [RES_W-1:0] result_o,
  output logic             res_bip_o,
  output logic             int_no,
  output logic             hold_o,
  output logic             bad_o
);
  localparam int CW = $clog2(RES_W + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(RES_W - 1);
  localparam logic [CW-1:0] DONE_CNT = CW'(RES_W);
  localparam logic [CW-1:0] ACQ_LAST = CW'(ACQ_TICKS - 1);
  localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

  seq_st_t state_q;
  logic [CW-1:0] cnt_q;
  logic [RES_W-1:0] trial_q, res_q;
  logic res_bip_q, int_nq, bad_q;
  logic [CW-1:0] bit_idx;

  assign bit_idx = LAST_BIT - cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      trial_q   <= '0;
      res_q     <= '0;
      res_bip_q <= 1'b0;
      int_nq    <= 1'b1;
      bad_q     <= 1'b0;
    end else begin
      if (wr_evt_i) begin
        int_nq  <= 1'b1;
        cnt_q   <= '0;
        trial_q <= '0;
        bad_q   <= 1'b0;
        if (!new_i.pd[1]) begin
          state_q <= ST_PDN;
        end else if (new_i.acq_ext) begin
          state_q <= ST_ACQ_EXT;
        end else if (state_q == ST_ACQ_EXT) begin
          state_q <= ST_CONV;
          trial_q <= MSB_ONLY;
          bad_q   <= ({new_i.single, new_i.uni, new_i.chan} !=
                      {cur_i.single, cur_i.uni, cur_i.chan});
        end else begin
          state_q <= ST_ACQ_INT;
        end
      end else if (tick_i) begin
        unique case (state_q)
          ST_ACQ_INT: begin
            if (cnt_q == ACQ_LAST) begin
              state_q <= ST_CONV;
              cnt_q   <= '0;
              trial_q <= MSB_ONLY;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_CONV: begin
            if (cnt_q == DONE_CNT) begin
              res_q     <= cur_i.uni ? trial_q : {~trial_q[RES_W-1], trial_q[RES_W-2:0]};
              res_bip_q <= ~cur_i.uni;
              int_nq    <= 1'b0;
              state_q   <= ST_IDLE;
              cnt_q     <= '0;
            end else begin
              for (int i = 0; i < RES_W; i++) begin
                if (CW'(i) == bit_idx) begin
                  trial_q[i] <= comp_i;
                  if (i > 0) trial_q[i-1] <= 1'b1;
                end
              end
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (rd_evt_i) int_nq <= 1'b1;
    end
  end

  assign trial_o   = trial_q;
  assign result_o  = res_q;
  assign res_bip_o = res_bip_q;
  assign int_no    = int_nq;
  assign hold_o    = (state_q == ST_CONV);
  assign bad_o     = bad_q;

  AST_INT_FROM_CONV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(int_nq) |-> $past(state_q == ST_CONV)); // R3
  AST_WR_RAISES_INT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_evt_i |=> int_nq); // R10
  AST_RD_RAISES_INT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_evt_i |=> int_nq); // R10
  AST_PDN_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PDN && !wr_evt_i) |=> (state_q == ST_PDN)); // R12
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV) |-> (cnt_q <= DONE_CNT)); // R6
  AST_WR_ABORTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_evt_i && state_q == ST_CONV && !new_i.acq_ext && new_i.pd[1]) |=> (state_q == ST_ACQ_INT)); // R9
endmodule

// File: rtl/sar_bus.sv
module sar_bus #(
  parameter int RES_W = 12,
  parameter int BUS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             rd_ni,
  input  logic             hben_i,
  input  logic [RES_W-1:0] result_i,
  input  logic             bip_i,
  output logic [BUS_W-1:0] d_o,
  output logic             d_oe_o,
  output logic             int_oe_o
);
  localparam int HI_W = RES_W - BUS_W;

  logic [BUS_W-1:0] hi_byte;

  for (genvar j = 0; j < BUS_W; j++) begin : g_hi
    if (j < HI_W) begin : g_data
      assign hi_byte[j] = result_i[BUS_W + j];
    end else begin : g_ext
      assign hi_byte[j] = bip_i & result_i[RES_W-1];
    end
  end

  assign d_o      = hben_i ? hi_byte : result_i[BUS_W-1:0];
  assign d_oe_o   = ~cs_ni & ~rd_ni;
  assign int_oe_o = ~cs_ni;

  AST_UNI_HI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_oe_o && hben_i && !bip_i) |-> (d_o[BUS_W-1:HI_W] == '0)); // R8
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int RES_W     = 12,
  parameter int BUS_W     = 8,
  parameter int ACQ_TICKS = 4,
  parameter int INT_DIV   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             wr_ni,
  input  logic             rd_ni,
  input  logic             hben_i,
  input  logic [BUS_W-1:0] d_i,
  output logic [BUS_W-1:0] d_o,
  output logic             d_oe_o,
  output logic             int_no,
  output logic             int_oe_o,
  input  logic             cclk_i,
  input  logic             comp_i,
  output logic [RES_W-1:0] trial_o,
  output logic [2:0]       chan_o,
  output logic             single_o,
  output logic             hold_o,
  output logic [1:0]       pwr_o,
  output logic             int_clk_o,
  output logic             conv_bad_o
);
  logic wr_q, rd_q, wr_evt, rd_evt, tick;
  ctl_t new_ctl, cur_ctl;
  logic [RES_W-1:0] result;
  logic res_bip;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= 1'b1;
      rd_q <= 1'b1;
    end else begin
      wr_q <= wr_ni;
      rd_q <= rd_ni;
    end
  end

  assign wr_evt  = ~wr_q & wr_ni & ~cs_ni;
  assign rd_evt  = rd_q & ~rd_ni & ~cs_ni;
  assign new_ctl = ctl_t'(d_i[7:0]);

  sar_cfg u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_evt_i  (wr_evt),
    .new_i     (new_ctl),
    .cfg_o     (cur_ctl),
    .int_clk_o (int_clk_o),
    .pwr_o     (pwr_o)
  );

  sar_tick #(.INT_DIV(INT_DIV)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_ni     (cs_ni),
    .cclk_i    (cclk_i),
    .int_clk_i (int_clk_o),
    .tick_o    (tick)
  );

  sar_core #(.RES_W(RES_W), .ACQ_TICKS(ACQ_TICKS)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_evt_i  (wr_evt),
    .rd_evt_i  (rd_evt),
    .tick_i    (tick),
    .new_i     (new_ctl),
    .cur_i     (cur_ctl),
    .comp_i    (comp_i),
    .trial_o   (trial_o),
    .result_o  (result),
    .res_bip_o (res_bip),
    .int_no    (int_no),
    .hold_o    (hold_o),
    .bad_o     (conv_bad_o)
  );

  sar_bus #(.RES_W(RES_W), .BUS_W(BUS_W)) u_bus (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_ni    (cs_ni),
    .rd_ni    (rd_ni),
    .hben_i   (hben_i),
    .result_i (result),
    .bip_i    (res_bip),
    .d_o      (d_o),
    .d_oe_o   (d_oe_o),
    .int_oe_o (int_oe_o)
  );

  assign chan_o   = cur_ctl.chan;
  assign single_o = cur_ctl.single;

  AST_CS_GATES_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && !wr_ni) |=> $stable(cur_ctl)); // R11
endmodule

// File: tb/sim_sar_seq.sv
module sim_sar_seq;
  logic clk = 0, rst_n = 0;
  logic cs_n = 0, wr_n = 1, rd_n = 1, hben = 0, cclk = 0;
  logic [7:0] d_in = 0;
  logic [11:0] vin = 0;
  logic [7:0] d_out;
  logic d_oe, int_n, int_oe, hold, int_clk, bad, single, comp;
  logic [11:0] trial;
  logic [2:0] chan;
  logic [1:0] pwr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign comp = (trial <= vin);

  sar_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .wr_ni(wr_n), .rd_ni(rd_n),
    .hben_i(hben), .d_i(d_in), .d_o(d_out), .d_oe_o(d_oe), .int_no(int_n),
    .int_oe_o(int_oe), .cclk_i(cclk), .comp_i(comp), .trial_o(trial),
    .chan_o(chan), .single_o(single), .hold_o(hold), .pwr_o(pwr),
    .int_clk_o(int_clk), .conv_bad_o(bad)
  );

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] b);
    d_in = b; wr_n = 0; cyc(2); wr_n = 1; cyc(2);
  endtask

  task automatic pulses(input int n);
    repeat (n) begin cclk = 1; cyc(2); cclk = 0; cyc(2); end
  endtask

  task automatic rd_byte(input logic h, output logic [7:0] v);
    hben = h; rd_n = 0; cyc(2); v = d_out; rd_n = 1; cyc(2);
  endtask

  function automatic logic [11:0] exp_res(input logic [11:0] v, input logic uni);
    return uni ? v : (v ^ 12'h800);
  endfunction

  function automatic logic [7:0] exp_hi(input logic [11:0] r, input logic uni);
    return {(uni ? 4'h0 : {4{r[11]}}), r[11:8]};
  endfunction

  function automatic logic [7:0] ctl(input logic [1:0] pd, input logic ax, input logic sg,
                                     input logic un, input logic [2:0] ch);
    return {pd, ax, sg, un, ch};
  endfunction

  task automatic check_result(input string req, input logic uni);
    logic [7:0] lo, hi;
    logic [11:0] r;
    r = exp_res(vin, uni);
    rd_byte(1'b0, lo);
    chk({req, " low byte"}, lo, r[7:0]);
    rd_byte(1'b1, hi);
    chk({req, " high byte"}, hi, exp_hi(r, uni));
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] b;
    void'($urandom(32'h5A12));
    cyc(3); rst_n = 1; cyc(2);

    // R1 reset state
    chk("R1 int_no", int_n, 1); chk("R1 int_clk", int_clk, 0);
    chk("R1 pwr", pwr, 0); chk("R1 hold", hold, 0); chk("R1 d_oe", d_oe, 0);

    // R2 R3 R6 internal acquisition, unipolar
    vin = 12'hA5C;
    wr_byte(ctl(2'b11, 0, 1, 1, 3'd6));
    chk("R2 chan", chan, 6); chk("R2 single", single, 1);
    pulses(16); chk("R3 int before 17th tick", int_n, 1);
    pulses(1);  chk("R3 int at 17th tick", int_n, 0);
    check_result("R6", 1'b1);
    chk("R10 read raises int", int_n, 1);

    // R7 bipolar, negative and positive
    vin = 12'h123;
    wr_byte(ctl(2'b11, 0, 0, 0, 3'd1)); pulses(17);
    check_result("R7 neg", 1'b0);
    vin = 12'hF00;
    wr_byte(ctl(2'b11, 0, 0, 0, 3'd1)); pulses(17);
    check_result("R7 pos", 1'b0);

    // R4 R5 host-timed acquisition, matching
    vin = 12'h7FF;
    wr_byte(ctl(2'b11, 1, 1, 1, 3'd3)); pulses(40);
    chk("R4 no conv during open acq", int_n, 1); chk("R4 hold", hold, 0);
    wr_byte(ctl(2'b11, 0, 1, 1, 3'd3));
    chk("R5 match clean", bad, 0);
    pulses(12); chk("R4 int before 13th", int_n, 1);
    pulses(1);  chk("R4 int at 13th", int_n, 0);
    check_result("R4", 1'b1);

    // R5 mismatch flagged
    wr_byte(ctl(2'b11, 1, 1, 1, 3'd3));
    wr_byte(ctl(2'b11, 0, 1, 1, 3'd5));
    chk("R5 mismatch flag", bad, 1);
    pulses(13);
    wr_byte(ctl(2'b11, 0, 1, 1, 3'd5));
    chk("R5 cleared by plain write", bad, 0);
    pulses(17);

    // R10 write raises int
    chk("R10 int low before write", int_n, 0);
    wr_byte(ctl(2'b11, 0, 1, 1, 3'd0));
    chk("R10 write raises int", int_n, 1);

    // R9 abort during conversion
    pulses(10);
    chk("R9 converting", hold, 1);
    wr_byte(ctl(2'b11, 0, 1, 1, 3'd0));
    pulses(16); chk("R9 old int suppressed", int_n, 1);
    pulses(1);  chk("R9 new int", int_n, 0);

    // R11 chip select high
    cs_n = 1; cyc(2);
    chk("R11 int_oe", int_oe, 0);
    rd_n = 0; cyc(2); chk("R11 d_oe", d_oe, 0); rd_n = 1; cyc(2);
    wr_byte(ctl(2'b11, 0, 0, 0, 3'd2));
    cs_n = 0; cyc(2);
    chk("R11 read ignored", int_n, 0);
    chk("R11 write ignored", chan, 0);
    wr_byte(ctl(2'b11, 0, 1, 1, 3'd0));
    cs_n = 1; cyc(2); pulses(20); cs_n = 0; cyc(2);
    chk("R11 clock ignored", int_n, 1);
    pulses(17); chk("R11 resumes", int_n, 0);

    // R12 power-down codes
    wr_byte(ctl(2'b01, 0, 1, 1, 3'd0));
    chk("R12 standby pwr", pwr, 2'b01); chk("R12 clk kept ext", int_clk, 0);
    pulses(30); chk("R12 no conv standby", int_n, 1);
    wr_byte(ctl(2'b10, 0, 1, 1, 3'd0));
    chk("R12 internal sel", int_clk, 1); chk("R12 run pwr", pwr, 0);
    wr_byte(ctl(2'b00, 0, 1, 1, 3'd0));
    chk("R12 full pwr", pwr, 2'b10); chk("R12 clk kept int", int_clk, 1);
    cyc(120); chk("R12 no conv off", int_n, 1);

    // R13 internal clock conversion
    vin = 12'h3C9;
    wr_byte(ctl(2'b10, 0, 1, 1, 3'd2));
    cyc(40); chk("R13 not yet done", int_n, 1);
    cyc(60); chk("R13 done", int_n, 0);
    check_result("R13", 1'b1);
    wr_byte(ctl(2'b11, 0, 1, 1, 3'd0));
    chk("R12 ext sel", int_clk, 0);
    pulses(17);

    // R8 random mix of modes
    for (int k = 0; k < 30; k++) begin
      logic ax, un;
      logic [2:0] ch;
      ax = 1'($urandom); un = 1'($urandom); ch = 3'($urandom);
      vin = 12'($urandom);
      if (k == 0) vin = 12'h000;
      if (k == 1) vin = 12'hFFF;
      if (ax) begin
        wr_byte(ctl(2'b11, 1, 1, un, ch));
        pulses(int'($urandom_range(0, 5)));
        wr_byte(ctl(2'b11, 0, 1, un, ch));
        pulses(12);
      end else begin
        wr_byte(ctl(2'b11, 0, 1, un, ch));
        pulses(16);
      end
      chk("R8 int pending", int_n, 1);
      pulses(1);
      chk("R8 int done", int_n, 0);
      check_result("R8", un);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule